// File: doc/BRIEF.md
# Framed Transmit Byte Queue with Fill Thresholds

This block sits between a host that writes outgoing packets as 32-bit words and a MAC-side consumer that takes them one byte at a time. Every packet is written as a header word carrying its true byte length, followed by the payload rounded up to whole 32-bit words. The block holds these words in a queue and reports how many bytes of space remain. The drain side emits only the real payload bytes and skips the pad bytes. When a packet ends, the block records a completion status byte on a small last-in-first-out stack for the host to read and pop.

Two programmable byte thresholds shape the traffic. The availability threshold raises a one-cycle event once enough room has opened for the host to write its next packet. The start threshold lets the drain side begin a packet before the host has written all of it. If the drain side then runs out of data in the middle of a packet, that is an underrun: the rest of the packet is thrown away and the transmitter shuts itself off. A jabber indication shuts it off in the same way. The MAC is modelled only as a valid/ready byte sink with two injectable fault flags.

Both streams follow valid/ready rules. The host write port moves a word on any cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is low only while the queue is full. The drain port moves a byte on any cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` and `tx_data` hold their values. `tx_ready` may stay low for as long as the consumer needs. An underrun is declared only when the queue is empty during a packet, not when the consumer stalls.

Top module: `txf_tx_fifo`

## Requirements
- R1: A header word holds the byte length L in bits [LEN_W-1:0] and a completion-request flag in bit 31. It is followed by ceil(L/4) data words. Byte k of the packet sits in bits [8*(k%4)+7 : 8*(k%4)] of data word k/4. The drain port emits exactly L bytes in order and never emits a pad byte. `tx_last` is high with byte L-1 only. A zero-length packet emits no bytes but still produces a status entry.
- R2: `free_bytes` equals DEPTH_BYTES minus 4 times the number of words held. Header words count as held, and so does any data word that has not been fully emitted or discarded. `wr_ready` is low exactly when `free_bytes` is 0.
- R3: `cmd_set_avail` stores `cmd_arg` as the availability threshold and arms the event. `txavail_evt` then pulses for one cycle the first time `free_bytes` is at least the threshold. It does not pulse again until the next `cmd_set_avail`.
- R4: `cmd_set_start` stores `cmd_arg` as the start threshold, which resets to all ones. With the transmitter enabled, a packet at the head starts in either of two cases. The first is that all of its words are present. The second is that 4 times the number of its data words present is at least the start threshold.
- R5: Each finished packet pushes one status byte. Bit 7 is complete and is always 1. Bit 6 copies the request flag. Bit 5 is jabber, bit 4 is underrun, bit 3 is maximum collisions and bit 2 is stack overflow. All other bits are 0.
- R6: The status store is a stack of STAT_DEPTH entries. `stat_top` shows the newest entry, or 0 when the stack is empty. A one-cycle `stat_pop` removes the newest entry. `stat_pending` is high while any entry remains. A push onto a full stack discards the new byte and sets bit 2 of the newest entry.
- R7: If the queue is empty while a started packet still has bytes to send, the packet is marked underrun. No further bytes of it are emitted, and its remaining data words are discarded as they arrive. Its status is pushed once the last of them has been discarded.
- R8: A packet with underrun or jabber clears `tx_enabled` when it finishes. While `tx_enabled` is low, no new packet starts, until `cmd_tx_enable` is given.
- R9: `cmd_tx_reset` empties the queue, so `free_bytes` returns to DEPTH_BYTES. It also empties the status stack, clears `tx_enabled` and re-aligns the host port to expect a header word.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged on the next cycle.
- R11: If `mac_maxcoll` is high on any cycle while a packet is being sent, that packet's status gets bit 3. The transmitter stays enabled. If `mac_jabber` is high on any such cycle, the status gets bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host word valid |
| wr_ready | output | 1 | Queue can accept a word |
| wr_data | input | 32 | Host word (header or data) |
| free_bytes | output | FBW | Free space in bytes |
| cmd_arg | input | FBW | Threshold value for the set commands |
| cmd_set_avail | input | 1 | Store availability threshold and arm event |
| cmd_set_start | input | 1 | Store start threshold |
| cmd_tx_enable | input | 1 | Enable transmitter |
| cmd_tx_reset | input | 1 | Clear queue and stack, disable transmitter |
| txavail_evt | output | 1 | One-cycle space-available event |
| tx_enabled | output | 1 | Transmitter enabled |
| tx_valid | output | 1 | Drain byte valid |
| tx_ready | input | 1 | Consumer takes byte |
| tx_data | output | 8 | Drain byte |
| tx_last | output | 1 | Final byte of packet |
| mac_maxcoll | input | 1 | Injected maximum-collision flag |
| mac_jabber | input | 1 | Injected jabber flag |
| stat_top | output | 8 | Newest status entry |
| stat_pop | input | 1 | Pop newest status entry |
| stat_pending | output | 1 | Status stack not empty |

## Verification
The bench sweeps packet lengths across every remainder modulo four. If pad skipping or last-byte marking were wrong, extra bytes would leak out or `tx_last` would be misplaced. It fills the queue exactly to zero free space, so an off-by-one in the word count would either drop `wr_ready` too early or let a write overrun the queue. It builds a real underrun by releasing a partial packet through the start threshold and then stalling the host. A design that mishandled this would keep emitting the late bytes, lose word alignment for the next packet, or stay enabled. It also pushes one status byte past the stack depth, where a wrong design would overwrite an older entry or lose the overflow mark.

// File: rtl/txf_pkg.sv
package txf_pkg;
  localparam int ST_OVF   = 2;
  localparam int ST_MAXC  = 3;
  localparam int ST_UNDER = 4;
  localparam int ST_JAB   = 5;
  localparam int ST_REQ   = 6;
  localparam int ST_DONE  = 7;

  typedef enum logic [1:0] {
    DR_IDLE = 2'd0,
    DR_SEND = 2'd1,
    DR_DROP = 2'd2,
    DR_FIN  = 2'd3
  } drain_st_t;
endpackage

// File: rtl/txf_wordq.sv
module txf_wordq #(
  parameter int DEPTH_W = 512,
  localparam int AW = $clog2(DEPTH_W),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [31:0]   push_data,
  input  logic          pop,
  output logic [31:0]   head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH_W);

  logic [31:0]   mem [DEPTH_W];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  assert_no_pop_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/txf_stat_stack.sv
module txf_stat_stack
  import txf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IW = $clog2(DEPTH),
  localparam int NW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       push,
  input  logic [7:0] push_data,
  input  logic       pop,
  output logic [7:0] top,
  output logic       nonempty
);
  localparam logic [NW-1:0] FULL_CNT = NW'(DEPTH);
  localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

  logic [7:0]    ent [DEPTH];
  logic [NW-1:0] cnt;
  logic [IW-1:0] wr_idx, top_idx;

  assign wr_idx   = cnt[IW-1:0];
  assign top_idx  = cnt[IW-1:0] - 1'b1;
  assign nonempty = (cnt != '0);
  assign top      = nonempty ? ent[top_idx] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      cnt <= '0;
    end else begin
      unique case ({push, pop})
        2'b10: begin
          if (cnt < FULL_CNT) begin
            ent[wr_idx] <= push_data;
            cnt         <= cnt + 1'b1;
          end else begin
            ent[LAST_IDX][ST_OVF] <= 1'b1;
          end
        end
        2'b01: if (nonempty) cnt <= cnt - 1'b1;
        2'b11: begin
          if (nonempty) ent[top_idx] <= push_data;
          else begin
            ent[0] <= push_data;
            cnt    <= NW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assert_stack_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);
  assert_full_push_marks_R6: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (push && !pop && cnt == FULL_CNT) |=> (cnt == FULL_CNT && top[ST_OVF]));
  assert_entry_complete_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nonempty |-> top[ST_DONE]);
endmodule

// File: rtl/txf_drain.sv
module txf_drain
  import txf_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int CW    = 10,
  localparam int FBW  = CW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           tx_en,
  input  logic [FBW-1:0] start_thr,
  input  logic           frames_ready,
  input  logic [31:0]    q_head,
  input  logic [CW-1:0]  q_count,
  input  logic           q_empty,
  output logic           q_pop,
  output logic           tx_valid,
  input  logic           tx_ready,
  output logic [7:0]     tx_data,
  output logic           tx_last,
  input  logic           mac_maxcoll,
  input  logic           mac_jabber,
  output logic           st_push,
  output logic [7:0]     st_data,
  output logic           frame_fin,
  output logic           fault
);
  drain_st_t        state;
  logic [LEN_W-1:0] rem_bytes;
  logic [LEN_W-2:0] words_left;
  logic [1:0]       bidx;
  logic             req, f_under, f_col, f_jab;

  logic [LEN_W:0]   wsum;
  logic [LEN_W-2:0] hdr_words;
  logic [LEN_W-1:0] hdr_len;
  logic [FBW-1:0]   buffered;
  logic             go, hs, word_end;

  assign hdr_len   = q_head[LEN_W-1:0];
  assign wsum      = {1'b0, hdr_len} + (LEN_W+1)'(3);
  assign hdr_words = wsum[LEN_W:2];
  assign buffered  = {q_count - 1'b1, 2'b00};
  assign go        = (state == DR_IDLE) && tx_en && !q_empty
                     && (frames_ready || buffered >= start_thr);

  assign tx_valid  = (state == DR_SEND) && !q_empty;
  assign tx_data   = q_head[{bidx, 3'b000} +: 8];
  assign tx_last   = (rem_bytes == LEN_W'(1));
  assign hs        = tx_valid && tx_ready;
  assign word_end  = (bidx == 2'd3) || tx_last;

  always_comb begin
    q_pop = 1'b0;
    unique case (state)
      DR_IDLE: q_pop = go;
      DR_SEND: q_pop = hs && word_end;
      DR_DROP: q_pop = !q_empty;
      default: q_pop = 1'b0;
    endcase
  end

  assign st_push   = (state == DR_FIN);
  assign frame_fin = (state == DR_FIN);
  assign fault     = (state == DR_FIN) && (f_under || f_jab);
  always_comb begin
    st_data           = 8'h00;
    st_data[ST_DONE]  = 1'b1;
    st_data[ST_REQ]   = req;
    st_data[ST_JAB]   = f_jab;
    st_data[ST_UNDER] = f_under;
    st_data[ST_MAXC]  = f_col;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      state      <= DR_IDLE;
      rem_bytes  <= '0;
      words_left <= '0;
      bidx       <= '0;
      req        <= 1'b0;
      f_under    <= 1'b0;
      f_col      <= 1'b0;
      f_jab      <= 1'b0;
    end else begin
      unique case (state)
        DR_IDLE: if (go) begin
          rem_bytes  <= hdr_len;
          words_left <= hdr_words;
          req        <= q_head[31];
          bidx       <= '0;
          f_under    <= 1'b0;
          f_col      <= 1'b0;
          f_jab      <= 1'b0;
          state      <= (hdr_len == '0) ? DR_FIN : DR_SEND;
        end
        DR_SEND: begin
          f_col <= f_col | mac_maxcoll;
          f_jab <= f_jab | mac_jabber;
          if (hs) begin
            bidx      <= bidx + 1'b1;
            rem_bytes <= rem_bytes - 1'b1;
            if (word_end) words_left <= words_left - 1'b1;
            if (tx_last)  state <= DR_FIN;
          end else if (q_empty) begin
            f_under <= 1'b1;
            state   <= DR_DROP;
          end
        end
        DR_DROP: if (!q_empty) begin
          words_left <= words_left - 1'b1;
          if (words_left == LEN_W'(1)) state <= DR_FIN;
        end
        default: state <= DR_IDLE;
      endcase
    end
  end

  assert_hold_under_stall_R10: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  assert_gap_after_last_R1: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (hs && tx_last) |=> !tx_valid);
endmodule

// File: rtl/txf_tx_fifo.sv
module txf_tx_fifo #(
  parameter int DEPTH_BYTES = 2048,
  parameter int STAT_DEPTH  = 4,
  parameter int LEN_W       = 11,
  localparam int DEPTH_W    = DEPTH_BYTES / 4,
  localparam int AW         = $clog2(DEPTH_W),
  localparam int CW         = AW + 1,
  localparam int FBW        = CW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_valid,
  output logic           wr_ready,
  input  logic [31:0]    wr_data,
  output logic [FBW-1:0] free_bytes,
  input  logic [FBW-1:0] cmd_arg,
  input  logic           cmd_set_avail,
  input  logic           cmd_set_start,
  input  logic           cmd_tx_enable,
  input  logic           cmd_tx_reset,
  output logic           txavail_evt,
  output logic           tx_enabled,
  output logic           tx_valid,
  input  logic           tx_ready,
  output logic [7:0]     tx_data,
  output logic           tx_last,
  input  logic           mac_maxcoll,
  input  logic           mac_jabber,
  output logic [7:0]     stat_top,
  input  logic           stat_pop,
  output logic           stat_pending
);
  localparam logic [CW-1:0]  WORDS_CNT = CW'(DEPTH_W);
  localparam logic [FBW-1:0] BYTES_CNT = FBW'(DEPTH_BYTES);

  logic [31:0]      q_head;
  logic [CW-1:0]    q_count;
  logic             q_empty, q_full, q_pop;
  logic             wr_fire;
  logic [LEN_W-2:0] wr_rem;
  logic [LEN_W:0]   wsum;
  logic [LEN_W-2:0] new_words;
  logic             wr_frame_done;
  logic [CW-1:0]    frames_done;
  logic             frame_fin, fault, st_push;
  logic [7:0]       st_data;
  logic [FBW-1:0]   start_thr, avail_thr;
  logic             armed;

  assign wr_ready   = !q_full;
  assign wr_fire    = wr_valid && wr_ready;
  assign free_bytes = {WORDS_CNT - q_count, 2'b00};

  // host-side framing: a zero remaining-word count means a header is due
  assign wsum      = {1'b0, wr_data[LEN_W-1:0]} + (LEN_W+1)'(3);
  assign new_words = wsum[LEN_W:2];
  assign wr_frame_done = wr_fire &&
    ((wr_rem == '0) ? (new_words == '0) : (wr_rem == (LEN_W-1)'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n || cmd_tx_reset) begin
      wr_rem      <= '0;
      frames_done <= '0;
    end else begin
      if (wr_fire) wr_rem <= (wr_rem == '0) ? new_words : wr_rem - 1'b1;
      frames_done <= frames_done + CW'(wr_frame_done) - CW'(frame_fin);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_thr   <= '1;
      avail_thr   <= '0;
      armed       <= 1'b0;
      txavail_evt <= 1'b0;
    end else begin
      txavail_evt <= 1'b0;
      if (cmd_set_start) start_thr <= cmd_arg;
      if (cmd_set_avail) begin
        avail_thr <= cmd_arg;
        armed     <= 1'b1;
      end else if (armed && free_bytes >= avail_thr) begin
        txavail_evt <= 1'b1;
        armed       <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cmd_tx_reset) tx_enabled <= 1'b0;
    else if (cmd_tx_enable)     tx_enabled <= 1'b1;
    else if (fault)             tx_enabled <= 1'b0;
  end

  txf_wordq #(.DEPTH_W(DEPTH_W)) u_q (
    .clk(clk), .rst_n(rst_n), .flush(cmd_tx_reset),
    .push(wr_fire), .push_data(wr_data), .pop(q_pop),
    .head(q_head), .count(q_count), .empty(q_empty), .full(q_full)
  );

  txf_drain #(.LEN_W(LEN_W), .CW(CW)) u_drain (
    .clk(clk), .rst_n(rst_n), .flush(cmd_tx_reset),
    .tx_en(tx_enabled), .start_thr(start_thr),
    .frames_ready(frames_done != '0),
    .q_head(q_head), .q_count(q_count), .q_empty(q_empty), .q_pop(q_pop),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .mac_maxcoll(mac_maxcoll), .mac_jabber(mac_jabber),
    .st_push(st_push), .st_data(st_data), .frame_fin(frame_fin), .fault(fault)
  );

  txf_stat_stack #(.DEPTH(STAT_DEPTH)) u_stat (
    .clk(clk), .rst_n(rst_n), .flush(cmd_tx_reset),
    .push(st_push), .push_data(st_data), .pop(stat_pop),
    .top(stat_top), .nonempty(stat_pending)
  );

  assert_avail_met_R3: assert property (@(posedge clk) disable iff (!rst_n)
    txavail_evt |-> $past(free_bytes >= avail_thr));
  assert_fault_disables_R8: assert property (@(posedge clk) disable iff (!rst_n || cmd_tx_reset)
    (fault && !cmd_tx_enable) |=> !tx_enabled);
  assert_reset_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_tx_reset |=> (free_bytes == BYTES_CNT && !stat_pending && !tx_enabled));
endmodule

// File: tb/tb_txf_tx_fifo.sv
`timescale 1ns/1ps
module tb_txf_tx_fifo;
  localparam int DB = 64, SD = 4, LW = 8, FBW = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, cmd_set_avail = 1'b0, cmd_set_start = 1'b0;
  logic cmd_tx_enable = 1'b0, cmd_tx_reset = 1'b0, tx_ready = 1'b1;
  logic mac_maxcoll = 1'b0, mac_jabber = 1'b0, stat_pop = 1'b0;
  logic [31:0] wr_data = '0;
  logic [FBW-1:0] cmd_arg = '0;
  logic wr_ready, txavail_evt, tx_enabled, tx_valid, tx_last, stat_pending;
  logic [FBW-1:0] free_bytes;
  logic [7:0] tx_data, stat_top;

  int checks = 0, errors = 0, rx_n = 0, evt_cnt = 0;
  logic [7:0] rx_b [256];
  logic       rx_l [256];
  bit rdy_mode = 0;
  logic [7:0] lfsr = 8'h5A;

  txf_tx_fifo #(.DEPTH_BYTES(DB), .STAT_DEPTH(SD), .LEN_W(LW)) dut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready = rdy_mode ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    if (tx_valid && tx_ready && rx_n < 256) begin
      rx_b[rx_n] = tx_data;
      rx_l[rx_n] = tx_last;
      rx_n = rx_n + 1;
    end
    if (txavail_evt) evt_cnt = evt_cnt + 1;
  end

  function automatic logic [7:0] pat(int len, int k);
    return 8'((len * 7 + k * 3 + 1) & 255);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic put(logic [31:0] w);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = w;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    #1 wr_valid = 1'b0;
  endtask

  task automatic put_hdr(int len, bit req);
    put({req, 23'd0, 8'(len)});
  endtask

  task automatic put_data(int len, int first_w, int n_w);
    for (int j = first_w; j < first_w + n_w; j++) begin
      logic [31:0] w;
      for (int b = 0; b < 4; b++)
        w[8*b +: 8] = (4*j + b < len) ? pat(len, 4*j + b) : 8'hEE;
      put(w);
    end
  endtask

  task automatic pulse_cmd(ref logic sig);
    @(negedge clk);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic set_start(int v);
    @(negedge clk);
    cmd_arg = FBW'(v);
    cmd_set_start = 1'b1;
    @(negedge clk);
    cmd_set_start = 1'b0;
  endtask

  task automatic wait_stat(string tag);
    int n = 0;
    while (!stat_pending && n < 600) begin
      @(negedge clk);
      n++;
    end
    #1;
    check(stat_pending, tag, 0, 1);
  endtask

  task automatic pop_stat();
    @(negedge clk);
    stat_pop = 1'b1;
    @(negedge clk);
    stat_pop = 1'b0;
    #1;
  endtask

  task automatic send_check(int len, bit req, logic [7:0] flags, bit do_pop, string tag);
    int bad = 0;
    rx_n = 0;
    put_hdr(len, req);
    put_data(len, 0, (len + 3) / 4);
    wait_stat(tag);
    tick(1);
    check(rx_n == len, {tag, " byte count"}, rx_n, len);
    for (int k = 0; k < len && k < rx_n; k++)
      if (rx_b[k] !== pat(len, k) || rx_l[k] !== (k == len - 1)) bad++;
    check(bad == 0, {tag, " bytes and last"}, bad, 0);
    check(stat_top == (8'h80 | (8'(req) << 6) | flags), {tag, " status"},
          stat_top, 8'h80 | (8'(req) << 6) | flags);
    if (do_pop) pop_stat();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(1);
    // reset state
    check(free_bytes == FBW'(DB), "R2 reset free", free_bytes, DB);
    check(wr_ready && !tx_valid && !tx_enabled, "R9 reset idle", {wr_ready, tx_valid, tx_enabled}, 3'b100);
    check(!stat_pending && stat_top == 8'h00, "R6 reset empty stack", stat_top, 0);

    // R2/R3: fill to zero free space while disabled, then drain
    rx_n = 0;
    put_hdr(56, 1'b1);
    put_data(56, 0, 14);
    tick(1);
    check(free_bytes == 7'd4 && wr_ready, "R2 free after 15 words", free_bytes, 4);
    put_hdr(0, 1'b0);
    tick(1);
    check(free_bytes == 7'd0 && !wr_ready, "R2 full", {free_bytes, wr_ready}, 0);
    @(negedge clk);
    cmd_arg = 7'd20;
    cmd_set_avail = 1'b1;
    @(negedge clk);
    cmd_set_avail = 1'b0;
    evt_cnt = 0;
    tick(8);
    check(evt_cnt == 0, "R3 no event below threshold", evt_cnt, 0);
    check(!tx_valid && rx_n == 0, "R8 disabled holds", rx_n, 0);
    pulse_cmd(cmd_tx_enable);
    tick(150);
    check(evt_cnt == 1, "R3 single event", evt_cnt, 1);
    check(rx_n == 56, "R1 long packet bytes", rx_n, 56);
    check(stat_top == 8'h80, "R6 newest first", stat_top, 8'h80);
    pop_stat();
    check(stat_top == 8'hC0, "R6 older entry", stat_top, 8'hC0);
    pop_stat();
    check(!stat_pending && free_bytes == FBW'(DB), "R6 stack drained", free_bytes, DB);

    // R1/R5: sweep lengths over all pad remainders
    for (int len = 0; len <= 16; len++)
      send_check(len, len[0], 8'h00, 1'b1, $sformatf("R1 sweep len %0d", len));

    // R10: consumer back-pressure
    rdy_mode = 1;
    send_check(11, 1'b1, 8'h00, 1'b1, "R10 stall len 11");
    send_check(13, 1'b0, 8'h00, 1'b1, "R10 stall len 13");
    rdy_mode = 0;

    // R6: overflow of the status stack
    for (int i = 0; i < 5; i++) begin
      put_hdr(0, !i[0]);
      tick(4);
    end
    tick(4);
    check(stat_top == 8'h84, "R6 overflow mark on newest", stat_top, 8'h84);
    pop_stat();
    check(stat_top == 8'hC0, "R6 pop 2", stat_top, 8'hC0);
    pop_stat();
    check(stat_top == 8'h80, "R6 pop 3", stat_top, 8'h80);
    pop_stat();
    check(stat_top == 8'hC0, "R6 pop 4", stat_top, 8'hC0);
    pop_stat();
    check(!stat_pending && stat_top == 8'h00, "R6 empty after pops", stat_top, 0);

    // R4/R7: early start then underrun
    set_start(8);
    rx_n = 0;
    put_hdr(20, 1'b0);
    put_data(20, 0, 1);
    tick(8);
    check(rx_n == 0 && !stat_pending, "R4 below start threshold", rx_n, 0);
    put_data(20, 1, 1);
    tick(25);
    check(rx_n == 8, "R4 early start bytes", rx_n, 8);
    check(!stat_pending, "R7 status waits for discard", stat_pending, 0);
    put_data(20, 2, 3);
    wait_stat("R7 underrun status");
    tick(2);
    check(stat_top == 8'h90, "R7 underrun bits", stat_top, 8'h90);
    check(rx_n == 8, "R7 no late bytes", rx_n, 8);
    check(!tx_enabled, "R8 underrun disables", tx_enabled, 0);
    check(free_bytes == FBW'(DB), "R7 words discarded", free_bytes, DB);
    pop_stat();

    // R8: nothing starts until re-enabled
    rx_n = 0;
    put_hdr(4, 1'b0);
    put_data(4, 0, 1);
    tick(20);
    check(rx_n == 0 && !stat_pending, "R8 stays off", rx_n, 0);
    pulse_cmd(cmd_tx_enable);
    wait_stat("R8 resumes");
    tick(1);
    check(rx_n == 4 && stat_top == 8'h80, "R8 resumed packet", stat_top, 8'h80);
    pop_stat();

    // R11 and jabber
    mac_maxcoll = 1'b1;
    send_check(6, 1'b0, 8'h08, 1'b1, "R11 max collisions");
    mac_maxcoll = 1'b0;
    check(tx_enabled, "R11 stays enabled", tx_enabled, 1);
    mac_jabber = 1'b1;
    send_check(5, 1'b1, 8'h20, 1'b0, "R11 jabber");
    mac_jabber = 1'b0;
    tick(1);
    check(!tx_enabled, "R8 jabber disables", tx_enabled, 0);

    // R9: reset with a partial packet and a pending status
    put_hdr(12, 1'b0);
    put_data(12, 0, 1);
    tick(1);
    check(free_bytes == 7'd56, "R2 partial held", free_bytes, 56);
    pulse_cmd(cmd_tx_reset);
    tick(1);
    check(free_bytes == FBW'(DB) && !stat_pending && !tx_enabled, "R9 cleared",
          {free_bytes, stat_pending, tx_enabled}, {7'(DB), 2'b00});
    set_start(127);
    pulse_cmd(cmd_tx_enable);
    send_check(5, 1'b0, 8'h00, 1'b1, "R9 realigned");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule